// File: doc/BRIEF.md
# Offload Engine Command Channel Queues

This block is the device-side control channel that sits between a host driver and an offload engine. It keeps four circular queues in on-chip storage. Three of them carry requests from the host to the engine: connection requests (listen, accept, connect, close), transmit requests and receive requests. The fourth is the event queue, which carries completion records from the engine back to the host. All queues share one completion path and one interrupt line.

The host works through a word-wide register port. Writing a descriptor to a queue's post address stores it in the slot under that queue's producer index and advances the index. The engine sees each host queue as a valid/ready pop port that gives out the oldest descriptor first. Once the engine has finished a request, it pushes a completion record through a valid/ready port. A completion record carries a connection identifier, status flags, a packet length and a packet pointer, all packed into one word. A transmit descriptor packs a payload length, a buffer address and control flags in the same way. A 2-bit kind code on the completion port tells the block when to raise the interrupt. For received data, the interrupt fires at once only if the host has a receive descriptor waiting. Without one, it waits until the host buffer is full.

Top module: `ofe_cmd_chan`

## Requirements
- R1: After reset every queue is empty and all producer and consumer indices read 0. The status word reads 0, `irq` is low, `desc_valid` is all zero and `cpl_ready` is high.
- R2: A host write to address 0 (connection queue), 1 (transmit queue) or 2 (receive queue) on a non-full queue has two effects. It stores `reg_wdata` in the slot under that queue's producer index, and it advances the index by one modulo the depth. The queue's `desc_valid` bit is high from the next cycle.
- R3: For host queue q, `desc_data[q*DW +: DW]` shows the oldest unconsumed descriptor whenever `desc_valid[q]` is high. A cycle with both `desc_valid[q]` and `desc_ready[q]` high consumes that descriptor and advances the consumer index. Descriptors leave in the order they were posted, across index wrap-around.
- R4: Each queue holds at most DEPTH-1 entries. It is full when the producer index plus one equals the consumer index, and empty when the two indices are equal. A host post to a full queue is dropped and leaves both indices unchanged. The drop sets that queue's overflow bit: status bit 0 for the connection queue, bit 1 for transmit and bit 2 for receive. The bit stays set until reset.
- R5: `cpl_ready` is high exactly when the event queue is not full. A cycle with both `cpl_valid` and `cpl_ready` high appends `cpl_data`. A host read of address 3 returns the oldest event record, or 0 when the event queue is empty. A host write to address 3 consumes that record. The write is ignored when the event queue is empty.
- R6: An accepted completion of kind 0 (request done), 2 (receive buffer full) or 3 (other) drives `irq` high from the next cycle.
- R7: An accepted completion of kind 1 (partial receive) drives `irq` high only if the receive queue holds at least one descriptor in that cycle. Otherwise the record is appended and `irq` is left as it was.
- R8: `irq` is level-style. Once high, it stays high until a host consume at address 3 makes the event consumer index equal to the producer index. It drops in the cycle after that consume.
- R9: Reading address 5, 6, 7 or 8 returns the connection, transmit, receive or event queue indices respectively. The producer index is in bits [7:0] and the consumer index in bits [15:8]. The status word at address 4 holds the overflow bits in [2:0] and `irq` in bit 3.
- R10: With `reg_rd` low, `reg_rdata` is 0. Reads of addresses 9 to 15 return 0, and writes to addresses 4 to 15 change no queue state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read enable |
| reg_addr | input | 4 | Host register word address |
| reg_wdata | input | DW | Host write data (descriptor word) |
| reg_rdata | output | DW | Host read data, combinational from `reg_addr` |
| desc_valid | output | 3 | Per host queue: a descriptor is available |
| desc_ready | input | 3 | Per host queue: engine takes the descriptor |
| desc_data | output | 3*DW | Oldest descriptor of each host queue, queue q at [q*DW +: DW] |
| cpl_valid | input | 1 | Engine offers a completion record |
| cpl_kind | input | 2 | 0 done, 1 partial receive, 2 receive buffer full, 3 other |
| cpl_data | input | DW | Completion record word |
| cpl_ready | output | 1 | Event queue can accept a record |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with its defaults: a 32-bit descriptor word and 3 index bits, so each queue has 8 slots and 7 usable entries. With 7-entry queues, each host queue can be driven past full three times over, which walks both indices through every slot, wraps them and produces drops at each wrap phase. The event queue is checked against all four completion kinds, with and without a pending receive descriptor. It is also filled to the full boundary, where a kind that would raise the interrupt has to be refused, and then drained one record at a time while the level hold of the interrupt is watched.

// File: rtl/ofe_chan_pkg.sv
package ofe_chan_pkg;

    // Host-side queues; the event queue is one more ring after them.
    localparam int NUM_HOSTQ = 3;
    localparam int NUM_RINGS = NUM_HOSTQ + 1;
    localparam int QID_RECV  = 2;

    typedef enum logic [3:0] {
        RA_POST_CONN = 4'd0,
        RA_POST_XMIT = 4'd1,
        RA_POST_RECV = 4'd2,
        RA_EVT       = 4'd3,
        RA_STATUS    = 4'd4,
        RA_PTR_CONN  = 4'd5,
        RA_PTR_XMIT  = 4'd6,
        RA_PTR_RECV  = 4'd7,
        RA_PTR_EVT   = 4'd8
    } reg_addr_e;

    typedef enum logic [1:0] {
        CK_DONE    = 2'd0,
        CK_RX_PART = 2'd1,
        CK_RX_FULL = 2'd2,
        CK_OTHER   = 2'd3
    } cpl_kind_e;

endpackage

// File: rtl/ofe_ring.sv
module ofe_ring #(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_o,
    output logic [AW-1:0] prod_o,
    output logic [AW-1:0] cons_o,
    output logic          empty_o,
    output logic          full_o
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            prod;
        logic [AW-1:0]            cons;
    } ring_t;

    ring_t r_d, r_q;
    logic  full_w, empty_w;

    always_comb begin
        r_d     = r_q;
        full_w  = (AW'(r_q.prod + 1'b1) == r_q.cons);
        empty_w = (r_q.prod == r_q.cons);
        // Fullness is judged on the current state; a pop in the same
        // cycle does not make room for a push.
        if (push_i && !full_w) begin
            r_d.mem[r_q.prod] = push_data_i;
            r_d.prod          = AW'(r_q.prod + 1'b1);
        end
        if (pop_i && !empty_w) begin
            r_d.cons = AW'(r_q.cons + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign head_o  = r_q.mem[r_q.cons];
    assign prod_o  = r_q.prod;
    assign cons_o  = r_q.cons;
    assign empty_o = empty_w;
    assign full_o  = full_w;

endmodule

// File: rtl/ofe_chan_ctl.sv
module ofe_chan_ctl
    import ofe_chan_pkg::*;
#(
    parameter int NQ = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] post_wr_i,
    input  logic [NQ-1:0] host_full_i,
    input  logic          cpl_acc_i,
    input  logic [1:0]    cpl_kind_i,
    input  logic          rx_pending_i,
    input  logic          evt_pop_i,
    input  logic          evt_last_i,
    output logic [NQ-1:0] ovf_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [NQ-1:0] ovf;
        logic          irq;
    } ctl_t;

    ctl_t c_d, c_q;
    logic raise, drain;

    always_comb begin
        c_d     = c_q;
        c_d.ovf = c_q.ovf | (post_wr_i & host_full_i);
        // Partial receive data interrupts only while a receive request waits.
        raise   = cpl_acc_i && ((cpl_kind_i != CK_RX_PART) || rx_pending_i);
        // The last record leaves the event queue and nothing new arrives.
        drain   = evt_pop_i && evt_last_i && !cpl_acc_i;
        c_d.irq = raise || (c_q.irq && !drain);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ovf_o = c_q.ovf;
    assign irq_o = c_q.irq;

endmodule

// File: rtl/ofe_reg_rd.sv
module ofe_reg_rd
    import ofe_chan_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 3,
    parameter int NQ = 3,
    parameter int NR = 4
) (
    input  logic           rd_i,
    input  logic [3:0]     addr_i,
    input  logic [DW-1:0]  evt_head_i,
    input  logic           evt_empty_i,
    input  logic [NQ-1:0]  ovf_i,
    input  logic           irq_i,
    input  logic [NR*AW-1:0] prod_i,
    input  logic [NR*AW-1:0] cons_i,
    output logic [DW-1:0]  rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            if (addr_i == RA_EVT) begin
                if (!evt_empty_i) rdata_o = evt_head_i;
            end else if (addr_i == RA_STATUS) begin
                rdata_o[NQ-1:0] = ovf_i;
                rdata_o[NQ]     = irq_i;
            end else begin
                for (int q = 0; q < NR; q++) begin
                    if (addr_i == 4'(int'(RA_PTR_CONN) + q)) begin
                        rdata_o[AW-1:0]  = prod_i[q*AW +: AW];
                        rdata_o[8 +: AW] = cons_i[q*AW +: AW];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ofe_cmd_chan.sv
module ofe_cmd_chan
    import ofe_chan_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [3:0]            reg_addr,
    input  logic [DW-1:0]         reg_wdata,
    output logic [DW-1:0]         reg_rdata,
    output logic [NUM_HOSTQ-1:0]  desc_valid,
    input  logic [NUM_HOSTQ-1:0]  desc_ready,
    output logic [NUM_HOSTQ*DW-1:0] desc_data,
    input  logic                  cpl_valid,
    input  logic [1:0]            cpl_kind,
    input  logic [DW-1:0]         cpl_data,
    output logic                  cpl_ready,
    output logic                  irq
);
    localparam int EVT = NUM_HOSTQ;

    logic [NUM_RINGS-1:0]         ring_push, ring_pop, ring_empty, ring_full;
    logic [NUM_RINGS-1:0][DW-1:0] ring_wdata, ring_head;
    logic [NUM_RINGS*AW-1:0]      ring_prod, ring_cons;
    logic [NUM_HOSTQ-1:0]         post_wr;
    logic [NUM_HOSTQ-1:0]         sticky_ovf;
    logic                         evt_pop, evt_last, cpl_acc;

    assign evt_pop  = reg_wr && (reg_addr == RA_EVT);
    assign cpl_acc  = cpl_valid && cpl_ready;
    assign cpl_ready = ~ring_full[EVT];
    assign evt_last = (ring_prod[EVT*AW +: AW] == AW'(ring_cons[EVT*AW +: AW] + 1'b1));

    for (genvar q = 0; q < NUM_RINGS; q++) begin : g_ring
        if (q < NUM_HOSTQ) begin : g_host
            assign post_wr[q]            = reg_wr && (reg_addr == 4'(q));
            assign ring_push[q]          = post_wr[q];
            assign ring_pop[q]           = desc_ready[q];
            assign ring_wdata[q]         = reg_wdata;
            assign desc_valid[q]         = ~ring_empty[q];
            assign desc_data[q*DW +: DW] = ring_head[q];
        end else begin : g_evt
            assign ring_push[q]  = cpl_valid;
            assign ring_pop[q]   = evt_pop;
            assign ring_wdata[q] = cpl_data;
        end

        ofe_ring #(.DW(DW), .AW(AW)) i_ring (
            .clk         (clk),
            .rst_n       (rst_n),
            .push_i      (ring_push[q]),
            .push_data_i (ring_wdata[q]),
            .pop_i       (ring_pop[q]),
            .head_o      (ring_head[q]),
            .prod_o      (ring_prod[q*AW +: AW]),
            .cons_o      (ring_cons[q*AW +: AW]),
            .empty_o     (ring_empty[q]),
            .full_o      (ring_full[q])
        );
    end

    ofe_chan_ctl #(.NQ(NUM_HOSTQ)) i_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .post_wr_i    (post_wr),
        .host_full_i  (ring_full[NUM_HOSTQ-1:0]),
        .cpl_acc_i    (cpl_acc),
        .cpl_kind_i   (cpl_kind),
        .rx_pending_i (~ring_empty[QID_RECV]),
        .evt_pop_i    (evt_pop),
        .evt_last_i   (evt_last),
        .ovf_o        (sticky_ovf),
        .irq_o        (irq)
    );

    ofe_reg_rd #(.DW(DW), .AW(AW), .NQ(NUM_HOSTQ), .NR(NUM_RINGS)) i_rd (
        .rd_i        (reg_rd),
        .addr_i      (reg_addr),
        .evt_head_i  (ring_head[EVT]),
        .evt_empty_i (ring_empty[EVT]),
        .ovf_i       (sticky_ovf),
        .irq_i       (irq),
        .prod_i      (ring_prod),
        .cons_i      (ring_cons),
        .rdata_o     (reg_rdata)
    );

endmodule

// File: rtl/ofe_cmd_chan_chk.sv
module ofe_cmd_chan_chk #(
    parameter int NQ = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [3:0]    reg_addr,
    input logic          cpl_valid,
    input logic          cpl_ready,
    input logic [1:0]    cpl_kind,
    input logic [NQ-1:0] desc_valid,
    input logic          irq,
    input logic [NQ-1:0] ovf
);
    logic evt_wr;
    assign evt_wr = reg_wr && (reg_addr == 4'd3);

    assert_post_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr < 4'd3) |=> desc_valid[$past(reg_addr[1:0])]);

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|ovf) |=> ((ovf & $past(ovf)) == $past(ovf)));

    assert_full_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpl_ready && !evt_wr) |=> !cpl_ready);

    assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready && cpl_kind != 2'd1) |=> irq);

    assert_partial_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && cpl_valid && cpl_ready && cpl_kind == 2'd1 && !desc_valid[2]) |=> !irq);

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !evt_wr) |=> irq);

    assert_irq_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !(cpl_valid && cpl_ready)) |=> !irq);

endmodule

bind ofe_cmd_chan ofe_cmd_chan_chk #(.NQ(3)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .cpl_valid  (cpl_valid),
    .cpl_ready  (cpl_ready),
    .cpl_kind   (cpl_kind),
    .desc_valid (desc_valid),
    .irq        (irq),
    .ovf        (sticky_ovf)
);

// File: tb/test_ofe_cmd_chan.sv
`timescale 1ns/1ps
module test_ofe_cmd_chan;
    localparam int DW = 32;
    localparam int AW = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr, reg_rd;
    logic [3:0]    reg_addr;
    logic [DW-1:0] reg_wdata, reg_rdata;
    logic [2:0]    desc_valid, desc_ready;
    logic [3*DW-1:0] desc_data;
    logic          cpl_valid;
    logic [1:0]    cpl_kind;
    logic [DW-1:0] cpl_data;
    logic          cpl_ready, irq;

    int n_cmp = 0;
    int n_bad = 0;

    // Bench model: indices, contents, sticky bits, interrupt level.
    int          prodm[4];
    int          consm[4];
    logic [31:0] qm[4][DEPTH];
    logic [2:0]  ovfm;
    logic        irqm;

    always #2.5 clk = ~clk;

    ofe_cmd_chan #(.DW(DW), .AW(AW)) i_ofe_cmd_chan (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
        .cpl_valid(cpl_valid), .cpl_kind(cpl_kind), .cpl_data(cpl_data),
        .cpl_ready(cpl_ready), .irq(irq)
    );

    function automatic int cnt(int q);
        return (prodm[q] - consm[q] + DEPTH) % DEPTH;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic hwr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic hrd(input logic [3:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1;
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic chk_ptr(input int q, input string tag);
        logic [31:0] d;
        hrd(4'(5 + q), d);
        chk(tag, d, (32'(consm[q]) << 8) | 32'(prodm[q]));
    endtask

    task automatic chk_status(input string tag);
        logic [31:0] d;
        hrd(4'd4, d);
        chk(tag, d, {28'd0, irqm, ovfm});
        chk({tag, " irq pin"}, {31'd0, irq}, {31'd0, irqm});
    endtask

    task automatic post(input int q, input logic [31:0] d);
        bit was_full;
        was_full = (cnt(q) == DEPTH - 1);
        hwr(4'(q), d);
        if (was_full) ovfm[q] = 1'b1;
        else begin
            qm[q][prodm[q]] = d;
            prodm[q] = (prodm[q] + 1) % DEPTH;
        end
    endtask

    task automatic take(input int q, input string tag);
        if (cnt(q) == 0) begin
            chk({tag, " valid low"}, {31'd0, desc_valid[q]}, 32'd0);
        end else begin
            chk({tag, " valid"}, {31'd0, desc_valid[q]}, 32'd1);
            chk({tag, " data"}, desc_data[q*DW +: DW], qm[q][consm[q]]);
            desc_ready[q] = 1'b1;
            @(negedge clk);
            desc_ready[q] = 1'b0;
            consm[q] = (consm[q] + 1) % DEPTH;
        end
    endtask

    task automatic push_cpl(input logic [1:0] k, input logic [31:0] d, input string tag);
        bit room;
        room = (cnt(3) != DEPTH - 1);
        chk({tag, " cpl_ready"}, {31'd0, cpl_ready}, {31'd0, room});
        @(negedge clk);
        cpl_valid = 1'b1; cpl_kind = k; cpl_data = d;
        @(negedge clk);
        cpl_valid = 1'b0;
        if (room) begin
            qm[3][prodm[3]] = d;
            prodm[3] = (prodm[3] + 1) % DEPTH;
            if (k != 2'd1 || cnt(2) > 0) irqm = 1'b1;
        end
    endtask

    task automatic evt_take(input string tag);
        logic [31:0] d;
        hrd(4'd3, d);
        chk({tag, " head"}, d, (cnt(3) > 0) ? qm[3][consm[3]] : 32'd0);
        hwr(4'd3, 32'hFFFF_FFFF);
        if (cnt(3) > 0) begin
            if (cnt(3) == 1) irqm = 1'b0;
            consm[3] = (consm[3] + 1) % DEPTH;
        end
        chk_ptr(3, {tag, " evt ptr"});
        chk({tag, " irq"}, {31'd0, irq}, {31'd0, irqm});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        desc_ready = '0; cpl_valid = 1'b0; cpl_kind = '0; cpl_data = '0;
        for (int q = 0; q < 4; q++) begin prodm[q] = 0; consm[q] = 0; end
        ovfm = '0; irqm = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int q = 0; q < 4; q++) chk_ptr(q, "R1 ptr");
        chk_status("R1 status");
        chk("R1 desc_valid", {29'd0, desc_valid}, 32'd0);
        chk("R1 cpl_ready", {31'd0, cpl_ready}, 32'd1);

        // R2 R3 R4 R9: overfill each host queue three times, drain in order
        for (int q = 0; q < 3; q++) begin
            for (int r = 0; r < 3; r++) begin
                for (int i = 0; i <= DEPTH; i++) begin
                    post(q, {8'hA0 + 8'(q), 8'(r), 16'(i)});
                    chk_ptr(q, "R2 R4 R9 post ptr");
                    chk("R2 valid after post", {31'd0, desc_valid[q]}, 32'd1);
                end
                chk_status("R4 overflow sticky");
                while (cnt(q) > 0) begin
                    take(q, "R3 pop");
                    chk_ptr(q, "R3 R9 pop ptr");
                end
                take(q, "R3 drained");
                chk("R3 other queues idle", {29'd0, desc_valid}, 32'd0);
            end
        end

        // R6 R7 R8: every kind, with and without a pending receive request
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 4; k++) begin
                if (p == 1) post(2, 32'hBEEF_0000 + 32'(k));
                push_cpl(2'(k), 32'hC0DE_0000 + 32'(p * 16 + k), "R6 R7 kind");
                chk("R6 R7 irq after push", {31'd0, irq}, {31'd0, irqm});
                chk_ptr(3, "R5 evt ptr after push");
                evt_take("R8 single drain");
                if (p == 1) take(2, "R7 recv release");
            end
        end

        // R5 R7: fill event queue with partial records, no receive pending
        for (int i = 0; i < DEPTH; i++) begin
            push_cpl(2'd1, 32'h5A00_0000 + 32'(i), "R5 R7 fill");
            chk("R7 partial stays quiet", {31'd0, irq}, 32'd0);
        end
        chk("R5 full refuses", {31'd0, cpl_ready}, 32'd0);
        push_cpl(2'd0, 32'hDEAD_0001, "R5 push on full");
        chk("R5 refused kind leaves irq", {31'd0, irq}, 32'd0);
        chk_ptr(3, "R5 full ptr");
        evt_take("R5 make room");
        push_cpl(2'd0, 32'h5A00_00FF, "R6 raise");
        chk("R6 irq up", {31'd0, irq}, 32'd1);
        while (cnt(3) > 0) evt_take("R8 hold until empty");
        evt_take("R5 pop on empty ignored");
        chk_status("R8 status after drain");

        // R10: read enable, unmapped addresses
        reg_addr = 4'd4;
        #1;
        chk("R10 rd low", reg_rdata, 32'd0);
        hrd(4'd12, d);
        chk("R10 unmapped read", d, 32'd0);
        post(0, 32'h1234_5678);
        hwr(4'd12, 32'hFFFF_FFFF);
        hwr(4'd4, 32'hFFFF_FFFF);
        for (int q = 0; q < 4; q++) chk_ptr(q, "R10 unmapped write");
        chk_status("R10 status unchanged");
        take(0, "R10 data intact");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule